// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Run-Time Miss Penalty

This block is a small data cache placed between a processor's memory stage and a slower backing store. The requester raises `req_valid` with an address, a read/write select and write data, and keeps the request steady until `rsp_ready` goes high. On a hit, `rsp_ready` rises in the same cycle. On a miss, `rsp_ready` stays low for a number of cycles taken from `miss_lat`. The line is then filled and the request completes.

The cache has sixteen one-word lines, indexed by the low address bits, and each line carries a valid bit and a tag. Stores write through to the backing store and allocate a line on a miss. The backing store is an internal array, so the block is self-contained. Because the penalty is an input and not a parameter, the cost of memory latency on pipeline stalls can be swept at run time. Two display outputs, `hit_flag` and `miss_flag`, mark each cycle in which a request is being served as a hit or as a miss.

Top module: `dcache_lat`

## Requirements
- R1: After reset every line is invalid, so the first access to any address is a miss. Backing word `a` holds `(3*a + 1) mod 2^DATA_W` after reset.
- R2: A read or write that hits asserts `rsp_ready` and `hit_flag` in the same cycle as `req_valid`. A read hit returns the cached word on `rsp_rdata`.
- R3: A miss with `miss_lat = N > 0` holds `rsp_ready` low for exactly N cycles, starting with the request cycle, and asserts it in cycle N. A read then returns the backing word.
- R4: With `miss_lat = 0` a miss completes in the request cycle with `miss_flag` high, and the line is still allocated, so a repeat access hits.
- R5: Every completed store updates the backing word at its address (write-through). After the line is evicted, a re-read returns the stored value.
- R6: A store miss pays the same penalty as a read miss and then allocates the line, so a following read of that address hits and returns the stored data.
- R7: Two addresses with the same low 4 index bits and different upper bits evict each other, so alternating between them misses every time.
- R8: The penalty is sampled when a miss starts. Changing `miss_lat` while that miss is pending does not change its length.
- R9: `hit_flag` and `miss_flag` are never high together. With no request pending, `rsp_ready` and both flags are low. `miss_flag` stays high from the start of a miss until its completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `rsp_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| miss_lat | input | LAT_W | Miss penalty in stall cycles |
| rsp_ready | output | 1 | Request completes this cycle |
| rsp_rdata | output | DATA_W | Load data, valid with `rsp_ready` |
| hit_flag | output | 1 | Current request served as a hit |
| miss_flag | output | 1 | Current request served as a miss |

## Verification
A line left valid when it should not be would show up as a missing stall: `hit_flag` rises and `rsp_ready` comes back in the request cycle, so the cycle count of that very access exposes it. A lost write-through shows up only later, when the line is evicted and re-read. For that reason the random stream uses a narrow address range to force frequent conflicts. A wrong penalty counter shows up as an off-by-one in the number of low `rsp_ready` cycles on the first miss after any latency change.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } miss_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    assign lk_idx = lk_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_addr[ADDR_W-1:IDX_W]);
    assign lk_data = dat_q[lk_idx];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_addr[ADDR_W-1:IDX_W];
            dat_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/cache_backing_mem.sv
module cache_backing_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i * 3 + 1);
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/cache_miss_ctrl.sv
module cache_miss_ctrl
    import dcache_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             lookup_hit,
    input  logic [LAT_W-1:0] miss_lat,
    output logic             done,
    output logic             hit_flag,
    output logic             miss_flag,
    output logic             fill,
    output logic             capture,
    output logic             waiting
);
    typedef struct packed {
        miss_state_e      st;
        logic [LAT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, cur_d;

    always_comb begin
        cur_d     = cur_q;
        done      = 1'b0;
        hit_flag  = 1'b0;
        miss_flag = 1'b0;
        fill      = 1'b0;
        capture   = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (lookup_hit) begin
                        done     = 1'b1;
                        hit_flag = 1'b1;
                    end else begin
                        miss_flag = 1'b1;
                        if (miss_lat == '0) begin
                            done = 1'b1;
                            fill = 1'b1;
                        end else begin
                            capture    = 1'b1;
                            cur_d.st   = ST_WAIT;
                            cur_d.cnt  = miss_lat - LAT_W'(1);
                        end
                    end
                end
            end
            ST_WAIT: begin
                miss_flag = 1'b1;
                if (cur_q.cnt == '0) begin
                    done     = 1'b1;
                    fill     = 1'b1;
                    cur_d.st = ST_IDLE;
                end else begin
                    cur_d.cnt = cur_q.cnt - LAT_W'(1);
                end
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    assign waiting = (cur_q.st == ST_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, cnt: '0};
        else        cur_q <= cur_d;
    end
endmodule

// File: rtl/dcache_lat.sv
module dcache_lat #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 16,
    parameter int LAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LAT_W-1:0]  miss_lat,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              hit_flag,
    output logic              miss_flag
);
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t held_q, held_d, eff;

    logic              lk_hit, fill, capture, waiting, done;
    logic [DATA_W-1:0] line_data, mem_data, line_wdata;
    logic              line_we, mem_we;

    always_comb begin
        held_d = held_q;
        if (capture) held_d = '{wr: req_write, addr: req_addr, wdata: req_wdata};
        eff = waiting ? held_q : '{wr: req_write, addr: req_addr, wdata: req_wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    cache_miss_ctrl #(.LAT_W(LAT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lookup_hit (lk_hit),
        .miss_lat   (miss_lat),
        .done       (done),
        .hit_flag   (hit_flag),
        .miss_flag  (miss_flag),
        .fill       (fill),
        .capture    (capture),
        .waiting    (waiting)
    );

    assign line_we    = fill || (hit_flag && eff.wr);
    assign line_wdata = eff.wr ? eff.wdata : mem_data;
    assign mem_we     = done && eff.wr;

    cache_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (eff.addr),
        .lk_hit  (lk_hit),
        .lk_data (line_data),
        .wr_en   (line_we),
        .wr_addr (eff.addr),
        .wr_data (line_wdata)
    );

    cache_backing_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (eff.addr),
        .rd_data (mem_data),
        .wr_en   (mem_we),
        .wr_addr (eff.addr),
        .wr_data (eff.wdata)
    );

    assign rsp_ready = done;
    assign rsp_rdata = hit_flag ? line_data : mem_data;
endmodule

// File: rtl/dcache_lat_chk.sv
module dcache_lat_chk #(
    parameter int LAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LAT_W-1:0] miss_lat,
    input logic             rsp_ready,
    input logic             hit_flag,
    input logic             miss_flag
);
    logic             in_miss;
    logic [LAT_W-1:0] lat_seen;
    logic [LAT_W:0]   stall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_miss   <= 1'b0;
            lat_seen  <= '0;
            stall_cnt <= '0;
        end else if (miss_flag) begin
            if (rsp_ready) begin
                in_miss <= 1'b0;
            end else begin
                in_miss <= 1'b1;
                if (!in_miss) begin
                    lat_seen  <= miss_lat;
                    stall_cnt <= (LAT_W+1)'(1);
                end else begin
                    stall_cnt <= stall_cnt + (LAT_W+1)'(1);
                end
            end
        end
    end

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_flag && miss_flag));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !in_miss) |-> (!rsp_ready && !hit_flag && !miss_flag));

    assert_hit_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_flag |-> rsp_ready);

    assert_miss_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_flag && !rsp_ready) |=> miss_flag);

    assert_penalty_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_flag && rsp_ready) |->
            (in_miss ? (stall_cnt == {1'b0, lat_seen}) : (miss_lat == '0)));
endmodule

bind dcache_lat dcache_lat_chk #(.LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .miss_lat  (miss_lat),
    .rsp_ready (rsp_ready),
    .hit_flag  (hit_flag),
    .miss_flag (miss_flag)
);

// File: tb/sim_dcache_lat.sv
`timescale 1ns/1ps
module sim_dcache_lat;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LINES  = 16;
    localparam int LAT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [LAT_W-1:0]  miss_lat = '0;
    logic              rsp_ready;
    logic [DATA_W-1:0] rsp_rdata;
    logic              hit_flag, miss_flag;

    int errors = 0;
    int checks = 0;

    logic [DATA_W-1:0] mem_m [1 << ADDR_W];
    bit                vld_m [LINES];
    int                tag_m [LINES];

    always #2 clk = ~clk;

    dcache_lat #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LAT_W(LAT_W)) u0 (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .miss_lat,
        .rsp_ready, .rsp_rdata, .hit_flag, .miss_flag
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input int a);
        return vld_m[a % LINES] && (tag_m[a % LINES] == a / LINES);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1 << ADDR_W); i++) mem_m[i] = DATA_W'(i * 3 + 1);
        for (int i = 0; i < LINES; i++) begin
            vld_m[i] = 1'b0;
            tag_m[i] = 0;
        end
    endtask

    // One access; lat_late is applied to miss_lat from the second cycle on.
    task automatic access(input bit wr, input int a, input int wd, input int lat,
                          input int lat_late, input string req);
        bit  exp_hit;
        int  exp_stall, stalls, exp_rd;
        bit  saw_hit, both;
        logic [DATA_W-1:0] got;
        exp_hit   = model_hit(a);
        exp_stall = exp_hit ? 0 : lat;
        exp_rd    = int'(mem_m[a]);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(a);
        req_wdata = DATA_W'(wd);
        miss_lat  = LAT_W'(lat);
        stalls    = 0;
        both      = 1'b0;
        #1;
        saw_hit = hit_flag;
        if (hit_flag && miss_flag) both = 1'b1;
        while (!rsp_ready && stalls < 1000) begin
            if (!miss_flag) both = 1'b1;
            @(negedge clk);
            miss_lat = LAT_W'(lat_late);
            #1;
            if (hit_flag) both = 1'b1;
            stalls++;
        end
        got = rsp_rdata;
        chk(stalls == exp_stall, req, stalls, exp_stall);
        chk(saw_hit == exp_hit, req, int'(saw_hit), int'(exp_hit));
        chk(!both, "R9", int'(both), 0);
        if (!wr) chk(got == DATA_W'(exp_rd), req, int'(got), exp_rd);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) mem_m[a] = DATA_W'(wd);
        vld_m[a % LINES] = 1'b1;
        tag_m[a % LINES] = a / LINES;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 / R9: idle outputs after reset
        chk(!rsp_ready && !hit_flag && !miss_flag, "R9",
            int'({rsp_ready, hit_flag, miss_flag}), 0);
        // R1: first read misses, returns reset pattern
        access(1'b0, 0, 0, 2, 2, "R1");
        access(1'b0, 77, 0, 3, 3, "R1");
        // R2: repeat is a hit
        access(1'b0, 77, 0, 3, 3, "R2");
        access(1'b1, 77, 16'h1234, 5, 5, "R2");
        access(1'b0, 77, 0, 5, 5, "R2");
        // R4: zero latency miss still allocates
        access(1'b0, 200, 0, 0, 0, "R4");
        access(1'b0, 200, 0, 4, 4, "R4");
        // R6: store miss allocates, then read hits with stored data
        access(1'b1, 33, 16'hBEEF, 3, 3, "R6");
        access(1'b0, 33, 0, 3, 3, "R6");
        // R5 / R7: evict via same index, then re-read from backing store
        access(1'b1, 5, 16'hA5A5, 2, 2, "R5");
        access(1'b0, 5 + 16, 0, 2, 2, "R7");
        access(1'b0, 5, 0, 2, 2, "R5");
        access(1'b0, 5 + 16, 0, 1, 1, "R7");
        // R8: change latency while a miss is pending
        access(1'b0, 150, 0, 6, 1, "R8");
        access(1'b0, 151, 0, 2, 9, "R8");
        // R3: long penalty
        access(1'b0, 99, 0, 20, 20, "R3");
        // R3 random mix
        for (int n = 0; n < 400; n++) begin
            bit wr;
            int a, lat;
            wr  = ($urandom % 10) < 4;
            a   = $urandom % 64;
            lat = $urandom % 6;
            access(wr, a, $urandom % 65536, lat, lat, "R3");
        end
        @(negedge clk);
        chk(!rsp_ready && !hit_flag && !miss_flag, "R9",
            int'({rsp_ready, hit_flag, miss_flag}), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule